// File: doc/BRIEF.md
# Bus-Mapped Stream FIFO Register Port

This block sits between an APB slave port and a streaming IP core. It carries one word queue in each direction, and each queue is reached through a single register address. The core pushes incoming words into the receive queue. Software reads them one at a time: every read of the receive data register returns the oldest word and removes it. Software writes outgoing words to the transmit data register. The core drains the transmit queue with a valid/ready handshake.

A third address returns a read-only status word with the empty flag, the full flag and the fill level of both queues. It also holds a sticky flag that records a transmit write dropped because the queue was full. The queue depth and the word width are parameters. The APB side never inserts wait states.

Register map (word index `paddr[3:2]`): 0 = receive data, 1 = transmit data, 2 = status, 3 = unused and reads as zero. Status bit layout: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full, bit 4 transmit overflow, bits 15:8 receive level, bits 23:16 transmit level. All other bits read as zero.

Top module: `apb_fifo_regs`

## Requirements
- R1: Reset empties both queues and clears the overflow flag. After reset both empty flags are 1, both full flags and both levels are 0, `txc_valid` is 0 and `tx_overflow` is 0.
- R2: A word on `rxc_data` enters the receive queue on a clock edge where `rxc_valid` and `rxc_ready` are both 1. `rxc_ready` equals the inverse of receive full.
- R3: An APB read access (`psel`, `penable` set, `pwrite` clear) to index 0 returns the oldest receive word, zero-extended on `prdata`, and removes it at that edge. Words leave in arrival order.
- R4: A read access to index 0 while the receive queue is empty returns zero and leaves the queue and all flags unchanged.
- R5: A write access to index 1 appends `pwdata[WIDTH-1:0]` to the transmit queue when the queue is not full.
- R6: A write access to index 1 while the transmit queue is full is dropped and sets `tx_overflow` (status bit 4). The flag stays set until reset.
- R7: A transmit word leaves the queue only on an edge where `txc_valid` and `txc_ready` are both 1. `txc_valid` is high exactly when the queue is non-empty. `txc_data` holds while `txc_valid` is 1 and `txc_ready` is 0.
- R8: A read access to index 2 returns the status word in the layout given above. The level outputs never exceed DEPTH.
- R9: `pready` is always 1. A setup phase (`psel` set, `penable` clear) neither pops nor pushes. `prdata` is zero outside a read access.
- R10: A core push and an APB pop on the same edge of the receive queue leave its level unchanged and keep word order.
- R11: Writes to index 0 or 2 and reads of index 1 or 3 change no state, and such reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| rxc_valid | input | 1 | Core offers a receive word |
| rxc_data | input | WIDTH | Receive word from the core |
| rxc_ready | output | 1 | Receive queue can accept a word |
| txc_valid | output | 1 | Transmit word available to the core |
| txc_data | output | WIDTH | Oldest transmit word |
| txc_ready | input | 1 | Core takes the transmit word |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_level | output | LVL_W | Receive fill level |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | LVL_W | Transmit fill level |
| tx_overflow | output | 1 | Sticky dropped-write flag |

## Verification
The hardest case to reach is the receive queue taking a core push and an APB pop on the same edge. The core word must be presented in the very cycle of the APB access phase. The bench holds `rxc_valid` high across a full two-cycle APB read while the queue is partly filled, so the setup cycle adds a word and the access cycle both adds and removes one. Overflow needs the transmit queue full while the core refuses words, so the bench keeps `txc_ready` low through DEPTH+1 writes before it drains the queue.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned APB_DW = 32;

  typedef enum logic [1:0] {
    REG_RX   = 2'd0,
    REG_TX   = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned ST_RX_EMPTY = 0;
  localparam int unsigned ST_RX_FULL  = 1;
  localparam int unsigned ST_TX_EMPTY = 2;
  localparam int unsigned ST_TX_FULL  = 3;
  localparam int unsigned ST_TX_OVF   = 4;
  localparam int unsigned ST_RX_LVL   = 8;
  localparam int unsigned ST_TX_LVL   = 16;

  function automatic logic [APB_DW-1:0] pack_status(
    input logic       rxe,
    input logic       rxf,
    input logic       txe,
    input logic       txf,
    input logic       ovf,
    input logic [7:0] rxl,
    input logic [7:0] txl
  );
    logic [APB_DW-1:0] w;
    w = '0;
    w[ST_RX_EMPTY] = rxe;
    w[ST_RX_FULL]  = rxf;
    w[ST_TX_EMPTY] = txe;
    w[ST_TX_FULL]  = txf;
    w[ST_TX_OVF]   = ovf;
    w[ST_RX_LVL +: 8] = rxl;
    w[ST_TX_LVL +: 8] = txl;
    return w;
  endfunction
endpackage

// File: rtl/sfr_fifo.sv
module sfr_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level,
  output logic             push_fire,
  output logic             pop_fire
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == LVL_W'(DEPTH));
  assign push_fire = push && !full;
  assign pop_fire  = pop && !empty;
  assign head      = mem[rd_ptr];
  assign level     = count;

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= bump(wr_ptr);
      if (pop_fire)  rd_ptr <= bump(rd_ptr);
      case ({push_fire, pop_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfr_apb_decode.sv
module sfr_apb_decode
  import sfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output reg_sel_e          sel,
  output logic              acc_rd,
  output logic              rd_rx,
  output logic              wr_tx,
  output logic              rd_stat
);
  logic access;

  assign sel     = reg_sel_e'(paddr[3:2]);
  assign access  = psel && penable;
  assign acc_rd  = access && !pwrite;
  assign rd_rx   = acc_rd && (sel == REG_RX);
  assign rd_stat = acc_rd && (sel == REG_STAT);
  assign wr_tx   = access && pwrite && (sel == REG_TX);
endmodule

// File: rtl/apb_fifo_regs.sv
module apb_fifo_regs
  import sfr_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              rxc_valid,
  input  logic [WIDTH-1:0]  rxc_data,
  output logic              rxc_ready,
  output logic              txc_valid,
  output logic [WIDTH-1:0]  txc_data,
  input  logic              txc_ready,
  output logic              rx_empty,
  output logic              rx_full,
  output logic [LVL_W-1:0]  rx_level,
  output logic              tx_empty,
  output logic              tx_full,
  output logic [LVL_W-1:0]  tx_level,
  output logic              tx_overflow
);
  reg_sel_e         sel;
  logic             acc_rd, rd_rx, wr_tx, rd_stat;
  logic [WIDTH-1:0] rx_head;
  logic             rx_push_fire, rx_pop_fire;
  logic             tx_push_fire, tx_pop_fire;
  logic             tx_drop;
  logic             ovf_q;

  sfr_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .sel(sel), .acc_rd(acc_rd), .rd_rx(rd_rx), .wr_tx(wr_tx), .rd_stat(rd_stat)
  );

  sfr_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_q (
    .clk(pclk), .rst_n(presetn),
    .push(rxc_valid), .wdata(rxc_data),
    .pop(rd_rx), .head(rx_head),
    .empty(rx_empty), .full(rx_full), .level(rx_level),
    .push_fire(rx_push_fire), .pop_fire(rx_pop_fire)
  );

  sfr_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_q (
    .clk(pclk), .rst_n(presetn),
    .push(wr_tx), .wdata(pwdata[WIDTH-1:0]),
    .pop(txc_ready), .head(txc_data),
    .empty(tx_empty), .full(tx_full), .level(tx_level),
    .push_fire(tx_push_fire), .pop_fire(tx_pop_fire)
  );

  assign tx_drop   = wr_tx && tx_full;
  assign rxc_ready = !rx_full;
  assign txc_valid = !tx_empty;
  assign pready    = 1'b1;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)     ovf_q <= 1'b0;
    else if (tx_drop) ovf_q <= 1'b1;
  end
  assign tx_overflow = ovf_q;

  always_comb begin
    prdata = '0;
    if (rd_rx && !rx_empty) begin
      prdata[WIDTH-1:0] = rx_head;
    end else if (rd_stat) begin
      prdata = pack_status(rx_empty, rx_full, tx_empty, tx_full, ovf_q,
                           8'(rx_level), 8'(tx_level));
    end
  end
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             penable,
  input logic [31:0]      prdata,
  input logic             rd_rx,
  input logic             rx_full,
  input logic             rx_empty,
  input logic             rxc_ready,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             rx_push_fire,
  input logic             rx_pop_fire,
  input logic             tx_push_fire,
  input logic             tx_drop,
  input logic             tx_overflow,
  input logic             txc_valid,
  input logic             txc_ready,
  input logic [WIDTH-1:0] txc_data
);
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rxc_ready);

  p_pop_drops_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_fire && !rx_push_fire) |=> (($past(rx_level) - rx_level) == LVL_W'(1)));

  p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_empty) |-> (prdata == 32'd0 && !rx_pop_fire));

  p_drop_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> tx_overflow);

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |=> tx_overflow);

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_valid && !txc_ready) |=> (txc_valid && $stable(txc_data)));

  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= LVL_W'(DEPTH)) && (tx_level <= LVL_W'(DEPTH)));

  p_setup_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |-> (!rx_pop_fire && !tx_push_fire));

  p_push_pop_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_fire && rx_push_fire) |=> $stable(rx_level));
endmodule

bind apb_fifo_regs sfr_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
  .prdata(prdata), .rd_rx(rd_rx), .rx_full(rx_full), .rx_empty(rx_empty),
  .rxc_ready(rxc_ready), .rx_level(rx_level), .tx_level(tx_level),
  .rx_push_fire(rx_push_fire), .rx_pop_fire(rx_pop_fire),
  .tx_push_fire(tx_push_fire), .tx_drop(tx_drop), .tx_overflow(tx_overflow),
  .txc_valid(txc_valid), .txc_ready(txc_ready), .txc_data(txc_data)
);

// File: tb/apb_fifo_regs_tb.sv
module apb_fifo_regs_tb;
  localparam int W = 8;
  localparam int D = 4;
  localparam int LW = $clog2(D + 1);

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready;
  logic rxc_valid = 0;
  logic [W-1:0] rxc_data = '0;
  logic rxc_ready, txc_valid, txc_ready = 0;
  logic [W-1:0] txc_data;
  logic rx_empty, rx_full, tx_empty, tx_full, tx_overflow;
  logic [LW-1:0] rx_level, tx_level;

  always #10 pclk = ~pclk;

  apb_fifo_regs #(.WIDTH(W), .DEPTH(D), .ADDR_W(4)) u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .rxc_valid(rxc_valid), .rxc_data(rxc_data),
    .rxc_ready(rxc_ready), .txc_valid(txc_valid), .txc_data(txc_data),
    .txc_ready(txc_ready), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_level(rx_level), .tx_empty(tx_empty), .tx_full(tx_full),
    .tx_level(tx_level), .tx_overflow(tx_overflow)
  );

  logic [W-1:0] rxq[$];
  logic [W-1:0] txq[$];
  bit ovf;
  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  function automatic logic [31:0] model_status();
    logic [31:0] s = 32'd0;
    s = s | ((rxq.size() == 0) ? 32'h1 : 32'h0);
    s = s | ((rxq.size() == D) ? 32'h2 : 32'h0);
    s = s | ((txq.size() == 0) ? 32'h4 : 32'h0);
    s = s | ((txq.size() == D) ? 32'h8 : 32'h0);
    s = s | (ovf ? 32'h10 : 32'h0);
    s = s | (32'(rxq.size()) << 8) | (32'(txq.size()) << 16);
    return s;
  endfunction

  function automatic logic [31:0] model_prdata();
    if (!(psel && penable && !pwrite)) return 32'd0;
    if (paddr[3:2] == 2'd0) return (rxq.size() > 0) ? 32'(rxq[0]) : 32'd0;
    if (paddr[3:2] == 2'd2) return model_status();
    return 32'd0;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("prdata", prdata, model_prdata());
    chk("pready", 32'(pready), 32'd1);
    chk("rxc_ready", 32'(rxc_ready), 32'(rxq.size() < D));
    chk("rx_empty", 32'(rx_empty), 32'(rxq.size() == 0));
    chk("rx_full", 32'(rx_full), 32'(rxq.size() == D));
    chk("rx_level", 32'(rx_level), 32'(rxq.size()));
    chk("tx_empty", 32'(tx_empty), 32'(txq.size() == 0));
    chk("tx_full", 32'(tx_full), 32'(txq.size() == D));
    chk("tx_level", 32'(tx_level), 32'(txq.size()));
    chk("txc_valid", 32'(txc_valid), 32'(txq.size() > 0));
    chk("tx_overflow", 32'(tx_overflow), 32'(ovf));
    if (txq.size() > 0) chk("txc_data", 32'(txc_data), 32'(txq[0]));
  endtask

  task automatic model_edge();
    bit acc = psel && penable;
    bit rpop = acc && !pwrite && paddr[3:2] == 2'd0 && rxq.size() > 0;
    bit rpush = rxc_valid && rxq.size() < D;
    bit twr = acc && pwrite && paddr[3:2] == 2'd1;
    bit tpop = txc_ready && txq.size() > 0;
    bit tpush = twr && txq.size() < D;
    if (!presetn) begin
      rxq.delete(); txq.delete(); ovf = 0;
      return;
    end
    if (twr && !tpush) ovf = 1;
    if (rpop) void'(rxq.pop_front());
    if (rpush) rxq.push_back(rxc_data);
    if (tpop) void'(txq.pop_front());
    if (tpush) txq.push_back(pwdata[W-1:0]);
  endtask

  task automatic step();
    #1;
    compare_all();
    @(posedge pclk);
    model_edge();
    @(negedge pclk);
  endtask

  task automatic apb(bit wr, logic [3:0] a, logic [31:0] d);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    step();
    penable = 1;
    step();
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic do_reset();
    presetn = 0;
    rxq.delete(); txq.delete(); ovf = 0;
    step();
    step();
    presetn = 1;
    step();
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge pclk);
    cur_req = "R1";
    do_reset();

    cur_req = "R2";
    for (int i = 0; i < 3; i++) begin
      rxc_valid = 1; rxc_data = W'(8'hA0 + i);
      step();
    end
    rxc_valid = 0;
    step();

    cur_req = "R3";
    for (int i = 0; i < 3; i++) apb(0, 4'h0, 0);
    cur_req = "R4";
    apb(0, 4'h0, 0);
    apb(0, 4'h0, 0);

    cur_req = "R2";
    rxc_valid = 1;
    for (int i = 0; i < D + 2; i++) begin
      rxc_data = W'(8'h30 + i);
      step();
    end
    rxc_valid = 0;
    cur_req = "R8";
    apb(0, 4'h8, 0);

    cur_req = "R9";
    psel = 1; penable = 0; pwrite = 0; paddr = 4'h0;
    step(); step();
    psel = 1; penable = 0; pwrite = 1; paddr = 4'h4; pwdata = 32'h77;
    step();
    psel = 0; pwrite = 0;
    step();

    cur_req = "R10";
    apb(0, 4'h0, 0);
    apb(0, 4'h0, 0);
    rxc_valid = 1; rxc_data = 8'h5C;
    apb(0, 4'h0, 0);
    rxc_data = 8'h5D;
    apb(0, 4'h0, 0);
    rxc_valid = 0;
    for (int i = 0; i < D; i++) apb(0, 4'h0, 0);

    cur_req = "R5";
    txc_ready = 0;
    apb(1, 4'h4, 32'hFFFF_FF11);
    apb(1, 4'h4, 32'h0000_0022);
    cur_req = "R7";
    step(); step();
    cur_req = "R6";
    for (int i = 0; i < D; i++) apb(1, 4'h4, 32'(8'hC0 + i));
    apb(0, 4'h8, 0);
    cur_req = "R7";
    txc_ready = 1;
    for (int i = 0; i < D + 2; i++) step();
    txc_ready = 0;
    cur_req = "R6";
    apb(0, 4'h8, 0);

    cur_req = "R11";
    apb(1, 4'h0, 32'h99);
    apb(1, 4'h8, 32'hFFFF_FFFF);
    rxc_valid = 1; rxc_data = 8'h42;
    step();
    rxc_valid = 0;
    apb(1, 4'h4, 32'h13);
    apb(0, 4'h4, 0);
    apb(0, 4'hC, 0);
    apb(0, 4'h8, 0);
    txc_ready = 1;
    step(); step();
    txc_ready = 0;

    cur_req = "R1";
    rxc_valid = 1; rxc_data = 8'h01;
    step();
    rxc_valid = 0;
    do_reset();
    apb(0, 4'h8, 0);

    finish_run();
  end
endmodule